// File: doc/BRIEF.md
# Five-Port Wormhole Flit Switch

This block is the switching core of one node in a two-dimensional mesh on-chip network. It has five links. One link faces the local processing element. The other four face the neighbouring nodes to the north, east, south and west. Every link carries flits in each direction under a valid/ready handshake. A flit moves across a link only in a cycle where both valid and ready are high. The sender must hold a flit and its valid steady until ready is seen. Ready never depends on valid in the same cycle.

Each input link feeds a small flit queue. When a head flit reaches the front of its queue, the switch derives the output port from the head's destination coordinates using dimension-ordered routing: X is corrected first, then Y. The head then competes for that output in a round-robin arbiter. A winning head locks the output to its input. The head, the body flits and the tail flit then cross the switch in order, with no other packet mixed in. The lock is released when the tail leaves. While the downstream side refuses flits, the whole worm waits inside the input queue. Once the queue is full, the input link refuses flits too.

Top module: `wh_switch`

## Requirements
- R1: After reset every out_valid is low and every in_ready is high.
- R2: A flit is {type[1:0], payload}. The type codes are 00 idle, 01 head, 10 body and 11 tail. In a head, payload[COORD_W-1:0] is the destination X and payload[2*COORD_W-1:COORD_W] is the destination Y. A head is routed to east if its X is greater than MY_X, and to west if its X is less than MY_X. When the X values match, it goes north if its Y is greater than MY_Y and south if its Y is less. When both match, it goes to the local port. The port indices are local=0, north=1, east=2, south=3, west=4.
- R3: Each input queue holds FIFO_DEPTH flits. in_ready is low exactly while its queue is full. With the output stalled, an input therefore accepts FIFO_DEPTH flits of a worm and then refuses more.
- R4: From the grant of a head until its tail leaves, an output carries only flits of that packet, and the head is the first flit shown. An input holds at most one output at a time.
- R5: Each output arbiter is round-robin. After a grant to input k, priority starts at input k+1. Two inputs that keep sending packets to the same output are served alternately.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_flit stays unchanged in the next cycle.
- R7: A blocked head holds back every later flit of its packet in the input queue. No flit is lost, and all of them leave in order once the output accepts again.
- R8: An output lock is released in the cycle its tail is transferred. If another head is already waiting, it is granted in the next cycle and shown one cycle after that. The output is therefore idle for exactly one cycle between the two packets.
- R9: An idle flit offered at an input is accepted and dropped. A body or tail flit at the front of an input that holds no output is dropped. Neither of them ever appears at an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per input link: flit offered |
| in_ready | output | 5 | Per input link: queue has room |
| in_flit | input | 90 | Per input link flit, NP x FLIT_W packed, link k at [k*18 +: 18] |
| out_valid | output | 5 | Per output link: flit shown |
| out_ready | input | 5 | Per output link: downstream accepts |
| out_flit | output | 90 | Per output link flit, same packing as in_flit |

## Verification
The hardest case to reach is a second head already sitting at the front of its queue at the moment another packet's tail is transferred on the same output. Only that case exposes the one-cycle release gap and the rotation of the arbiter's priority. The stimulus launches two multi-packet streams from two inputs toward the local output in the same cycle, with that output always ready. The bench then checks that the packets alternate between the sources and that each tail is followed by the next head exactly two cycles later. A separate case stalls an output until an input queue fills, so the bench can count the accepted flits.

// File: rtl/wh_pkg.sv
package wh_pkg;
  localparam int NPORT = 5;
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_SOUTH = 3;
  localparam int P_WEST  = 4;

  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } ftype_e;
endpackage

// File: rtl/wh_fifo.sv
module wh_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign rd_data = mem[rp];
endmodule

// File: rtl/wh_route.sv
module wh_route import wh_pkg::*; #(
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic [2*COORD_W-1:0] dest,
  output logic [NPORT-1:0]     port_oh
);
  logic [COORD_W-1:0] dx, dy;
  assign dx = dest[COORD_W-1:0];
  assign dy = dest[2*COORD_W-1:COORD_W];

  always_comb begin
    port_oh = '0;
    if (dx > COORD_W'(MY_X))      port_oh[P_EAST]  = 1'b1;
    else if (dx < COORD_W'(MY_X)) port_oh[P_WEST]  = 1'b1;
    else if (dy > COORD_W'(MY_Y)) port_oh[P_NORTH] = 1'b1;
    else if (dy < COORD_W'(MY_Y)) port_oh[P_SOUTH] = 1'b1;
    else                          port_oh[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        gnt[idx]   = 1'b1;
        gnt_idx    = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (en && found)
      ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/wh_switch.sv
module wh_switch import wh_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int COORD_W    = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2,
  localparam int NP        = NPORT,
  localparam int FLIT_W    = DATA_W + 2,
  localparam int PW        = $clog2(NP)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NP-1:0]              in_valid,
  output logic [NP-1:0]              in_ready,
  input  logic [NP-1:0][FLIT_W-1:0]  in_flit,
  output logic [NP-1:0]              out_valid,
  input  logic [NP-1:0]              out_ready,
  output logic [NP-1:0][FLIT_W-1:0]  out_flit
);
  logic [NP-1:0][FLIT_W-1:0] q_flit;
  logic [NP-1:0]             q_empty, q_full, q_wr, q_rd;
  ftype_e                    q_type [NP];
  logic [NP-1:0][NP-1:0]     route_oh;

  logic [NP-1:0]             in_bound;
  logic [NP-1:0][PW-1:0]     in_dst;

  logic [NP-1:0]             out_lock;
  logic [NP-1:0][PW-1:0]     out_owner;
  logic [NP-1:0][NP-1:0]     req_mat, gnt_mat;
  logic [NP-1:0][PW-1:0]     gnt_idx;
  logic [NP-1:0]             tail_out;

  // input side: queue + route per link
  for (genvar i = 0; i < NP; i++) begin : g_in
    assign q_wr[i]     = in_valid[i] && !q_full[i] &&
                         (in_flit[i][FLIT_W-1 -: 2] != FT_IDLE);
    assign in_ready[i] = !q_full[i];
    assign q_type[i]   = ftype_e'(q_flit[i][FLIT_W-1 -: 2]);

    wh_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (q_wr[i]),
      .wr_data (in_flit[i]),
      .full    (q_full[i]),
      .rd_en   (q_rd[i]),
      .rd_data (q_flit[i]),
      .empty   (q_empty[i])
    );

    wh_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_rt (
      .dest    (q_flit[i][2*COORD_W-1:0]),
      .port_oh (route_oh[i])
    );

    // bound input pops on downstream ready; unbound input drops stray data
    assign q_rd[i] = !q_empty[i] &&
                     (in_bound[i] ? out_ready[in_dst[i]] : (q_type[i] != FT_HEAD));
  end

  // request matrix: unbound head at queue front asks its routed output
  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req_mat[o][i] = !out_lock[o] && !q_empty[i] && !in_bound[i] &&
                        (q_type[i] == FT_HEAD) && route_oh[i][o];
  end

  // output side: arbiter + crossbar per link
  for (genvar o = 0; o < NP; o++) begin : g_out
    wh_rr_arb #(.N(NP)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_mat[o]),
      .en      (!out_lock[o]),
      .gnt     (gnt_mat[o]),
      .gnt_idx (gnt_idx[o])
    );

    assign out_valid[o] = out_lock[o] && !q_empty[out_owner[o]];
    assign out_flit[o]  = q_flit[out_owner[o]];
    assign tail_out[o]  = out_valid[o] && out_ready[o] &&
                          (out_flit[o][FLIT_W-1 -: 2] == FT_TAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lock  <= '0;
      out_owner <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (out_lock[o]) begin
          if (tail_out[o]) out_lock[o] <= 1'b0;
        end else if (|gnt_mat[o]) begin
          out_lock[o]  <= 1'b1;
          out_owner[o] <= gnt_idx[o];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_bound <= '0;
      in_dst   <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (in_bound[i]) begin
          if (q_rd[i] && q_type[i] == FT_TAIL) in_bound[i] <= 1'b0;
        end else begin
          for (int o = 0; o < NP; o++) begin
            if (gnt_mat[o][i]) begin
              in_bound[i] <= 1'b1;
              in_dst[i]   <= PW'(o);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/wh_switch_chk.sv
module wh_switch_chk #(
  parameter int NP     = 5,
  parameter int FLIT_W = 18,
  parameter int PW     = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NP-1:0]             out_valid,
  input logic [NP-1:0]             out_ready,
  input logic [NP-1:0][FLIT_W-1:0] out_flit,
  input logic [NP-1:0]             out_lock,
  input logic [NP-1:0][PW-1:0]     out_owner
);
  logic [NP-1:0][NP-1:0] held_by;

  always_comb begin
    for (int i = 0; i < NP; i++)
      for (int o = 0; o < NP; o++)
        held_by[i][o] = out_lock[o] && (out_owner[o] == PW'(i));
  end

  for (genvar o = 0; o < NP; o++) begin : g_o
    // R6: shown flit held while refused
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o]));

    // R8: one idle cycle after a tail leaves
    p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && out_ready[o] && out_flit[o][FLIT_W-1 -: 2] == 2'b11
      |=> !out_valid[o]);

    // R4: a newly locked output starts with the head flit
    p_head_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_lock[o]) |-> out_valid[o] && out_flit[o][FLIT_W-1 -: 2] == 2'b01);

    // R9: idle flits never leave
    p_no_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> out_flit[o][FLIT_W-1 -: 2] != 2'b00);
  end

  for (genvar i = 0; i < NP; i++) begin : g_i
    // R4: an input owns at most one output
    p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(held_by[i]) <= 1);
  end
endmodule

bind wh_switch wh_switch_chk #(.NP(NP), .FLIT_W(FLIT_W), .PW(PW)) chk_i (.*);

// File: tb/wh_switch_tb.sv
module wh_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int FW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]         in_valid = '0;
  logic [NP-1:0]         in_ready;
  logic [NP-1:0][FW-1:0] in_flit = '0;
  logic [NP-1:0]         out_valid;
  logic [NP-1:0]         out_ready = '1;
  logic [NP-1:0][FW-1:0] out_flit;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int acc0 = 0;
  logic [FW-1:0] rx  [NP][128];
  int            rxc [NP][128];
  int            rxn [NP] = '{default: 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  wh_switch dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (in_valid[0] && in_ready[0]) acc0 <= acc0 + 1;
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          rx[o][rxn[o]]  <= out_flit[o];
          rxc[o][rxn[o]] <= cyc;
          rxn[o]         <= rxn[o] + 1;
        end
      end
    end
  end

  function automatic logic [FW-1:0] mk(input logic [1:0] t, input logic [7:0] tag,
                                       input logic [7:0] lo);
    return {t, tag, lo};
  endfunction

  function automatic logic [FW-1:0] pkt_flit(input logic [7:0] tag, input logic [2:0] dx,
                                             input logic [2:0] dy, input int k, input int nb);
    if (k == 0)       return mk(2'b01, tag, {2'b00, dy, dx});
    else if (k <= nb) return mk(2'b10, tag, 8'(k));
    else              return mk(2'b11, tag, 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int p, input logic [FW-1:0] f);
    in_valid[p] = 1'b1;
    in_flit[p]  = f;
    while (!in_ready[p]) @(negedge clk);
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic send_pkt(input int p, input logic [7:0] tag, input logic [2:0] dx,
                          input logic [2:0] dy, input int nb);
    @(negedge clk);
    for (int k = 0; k < nb + 2; k++) begin
      in_valid[p] = 1'b1;
      in_flit[p]  = pkt_flit(tag, dx, dy, k, nb);
      while (!in_ready[p]) @(negedge clk);
      @(negedge clk);
    end
    in_valid[p] = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pkt(input int o, input int base, input logic [7:0] tag,
                           input logic [2:0] dx, input logic [2:0] dy, input int nb,
                           input string req);
    for (int k = 0; k < nb + 2; k++)
      check(rx[o][base+k] == pkt_flit(tag, dx, dy, k, nb), req,
            rx[o][base+k], pkt_flit(tag, dx, dy, k, nb));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == '0, "R1 out_valid", FW'(out_valid), '0);
    check(in_ready == '1, "R1 in_ready", FW'(in_ready), FW'(5'h1F));
  endtask

  task automatic t_route();
    logic [2:0] xs [5] = '{3'd2, 3'd2, 3'd5, 3'd2, 3'd0};
    logic [2:0] ys [5] = '{3'd2, 3'd4, 3'd0, 3'd0, 3'd7};
    for (int d = 0; d < NP; d++) begin
      int b0 = rxn[d];
      send_pkt(0, 8'h10 + 8'(d), xs[d], ys[d], 1);
      wait_cyc(8);
      checks++;
      if (rxn[d] != b0 + 3) begin
        failures++;
        $display("FAIL R2 port %0d count actual=%0d expected=%0d", d, rxn[d] - b0, 3);
      end else check_pkt(d, b0, 8'h10 + 8'(d), xs[d], ys[d], 1, "R2 route");
    end
  endtask

  task automatic t_backpressure();
    int b0 = rxn[2];
    int a0 = acc0;
    logic [FW-1:0] hd = pkt_flit(8'h30, 3'd6, 3'd2, 0, 4);
    out_ready[2] = 1'b0;
    fork send_pkt(0, 8'h30, 3'd6, 3'd2, 4); join_none
    wait_cyc(12);
    check(in_ready[0] == 1'b0, "R3 ready low when full", FW'(in_ready[0]), '0);
    check(acc0 - a0 == 4, "R3 accepted depth", FW'(acc0 - a0), FW'(4));
    check(out_valid[2] && out_flit[2] == hd, "R7 head waits at output", out_flit[2], hd);
    wait_cyc(3);
    check(out_valid[2] && out_flit[2] == hd, "R6 held under backpressure", out_flit[2], hd);
    check(rxn[2] == b0, "R7 nothing passed", FW'(rxn[2] - b0), '0);
    out_ready[2] = 1'b1;
    wait_cyc(14);
    check(rxn[2] == b0 + 6, "R7 worm count", FW'(rxn[2] - b0), FW'(6));
    check_pkt(2, b0, 8'h30, 3'd6, 3'd2, 4, "R7 worm order");
  endtask

  task automatic t_wormhole();
    int b0 = rxn[2];
    fork
      send_pkt(1, 8'hA1, 3'd7, 3'd1, 3);
      send_pkt(3, 8'hB3, 3'd4, 3'd3, 3);
    join
    wait_cyc(16);
    check(rxn[2] == b0 + 10, "R4 total flits", FW'(rxn[2] - b0), FW'(10));
    check_pkt(2, b0,     8'hA1, 3'd7, 3'd1, 3, "R4 first packet intact");
    check_pkt(2, b0 + 5, 8'hB3, 3'd4, 3'd3, 3, "R4 second packet intact");
  endtask

  task automatic t_fair();
    int b0 = rxn[0];
    logic [7:0] order [4] = '{8'h21, 8'h41, 8'h22, 8'h42};
    fork
      begin send_pkt(2, 8'h21, 3'd2, 3'd2, 1); send_pkt(2, 8'h22, 3'd2, 3'd2, 1); end
      begin send_pkt(4, 8'h41, 3'd2, 3'd2, 1); send_pkt(4, 8'h42, 3'd2, 3'd2, 1); end
    join
    wait_cyc(16);
    check(rxn[0] == b0 + 12, "R5 total flits", FW'(rxn[0] - b0), FW'(12));
    for (int p = 0; p < 4; p++) begin
      check_pkt(0, b0 + 3*p, order[p], 3'd2, 3'd2, 1, "R5 alternation");
      if (p > 0)
        check(rxc[0][b0+3*p] - rxc[0][b0+3*p-1] == 2, "R8 release gap",
              FW'(rxc[0][b0+3*p] - rxc[0][b0+3*p-1]), FW'(2));
    end
  endtask

  task automatic t_discard();
    int tot0 = rxn[0] + rxn[1] + rxn[2] + rxn[3] + rxn[4];
    int b0 = rxn[3];
    @(negedge clk);
    push(1, mk(2'b00, 8'hEE, 8'hEE));
    push(1, mk(2'b10, 8'hDD, 8'h01));
    push(1, mk(2'b11, 8'hDD, 8'hFF));
    send_pkt(1, 8'h55, 3'd2, 3'd0, 1);
    wait_cyc(10);
    check(rxn[0] + rxn[1] + rxn[2] + rxn[3] + rxn[4] == tot0 + 3, "R9 only packet leaves",
          FW'(rxn[0] + rxn[1] + rxn[2] + rxn[3] + rxn[4] - tot0), FW'(3));
    check_pkt(3, b0, 8'h55, 3'd2, 3'd0, 1, "R9 packet after strays");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_route();
    t_backpressure();
    t_wormhole();
    t_fair();
    t_discard();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule